// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block connects two 18-bit buses, A and B, with one independent data path in each direction. Each path holds one storage stage that works in three ways. With its latch enable high the stage is transparent. With the latch enable low and no qualifying clock edge the stage holds its value. With the latch enable low, an enabled rising edge on the path's own clock loads the stage. Each path has its own output enable, latch enable, clock and clock enable.

Bus pins are split into an input vector, a per-bit "driven" mask, an output vector and an output-enable vector. This keeps the block synthesizable, and a board-level wrapper can build real tri-state pads from these signals. A per-bit bus-hold register keeps the last driven value of each input bit. When a bit is undriven, the storage stage sees that held value. The per-direction clocks are treated as data and sampled by the system clock `clk`. A rising edge is a sample of 1 that follows a sample of 0. The reset is synchronous and active high.

Top module: `bxc_xcvr`

## Requirements
- R1: After reset, all stored and bus-hold values are zero. With latch enable low and output enable active, both outputs read 0 until the first load.
- R2: While a direction's latch enable is 1, its output equals its effective input in the same cycle, with no clock edge needed.
- R3: While the latch enable is 0 and no enabled rising clock edge is seen, the output keeps its stored value, whatever the input does.
- R4: When the latch enable is 0 and the clock enable is 0, a rising edge of the direction clock loads the effective input. The edge is a clock sample of 1 at a `clk` edge whose previous sample was 0. The new value appears right after that `clk` edge.
- R5: The clock enable is active low. While it is 1, rising edges of the direction clock do not change the stored value.
- R6: While the stage is transparent, the stored value follows the input. When the latch enable falls, the last transparent value is kept.
- R7: The output enable is active low. When it is 0, every bit of the output-enable vector is 1 and the output carries the path data. When it is 1, the output-enable vector is all zeros and the output vector reads 0. Loading still takes place while the output is disabled.
- R8: Each input bit whose driven-mask bit is 1 updates that bit's bus-hold register on a `clk` edge. A bit whose mask bit is 0 presents its held value to the storage stage.
- R9: The two directions are independent. The controls and data of one direction never change the other direction's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | A-bus input value |
| a_in_vld | input | 18 | Per-bit mask: 1 means the A-bus bit is driven |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| ck_ab | input | 1 | A-to-B load clock, sampled by clk |
| cken_ab_n | input | 1 | A-to-B clock enable, active low |
| b_out | output | 18 | Data driven onto the B bus |
| b_oe | output | 18 | Per-bit drive enable for the B bus |
| b_in | input | 18 | B-bus input value |
| b_in_vld | input | 18 | Per-bit mask: 1 means the B-bus bit is driven |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| ck_ba | input | 1 | B-to-A load clock, sampled by clk |
| cken_ba_n | input | 1 | B-to-A clock enable, active low |
| a_out | output | 18 | Data driven onto the A bus |
| a_oe | output | 18 | Per-bit drive enable for the A bus |

## Verification
A stimulus table drives both directions through several sequences:
- transparent steps with different data;
- latch-enable falls followed by input changes;
- clock high-levels with no new edge, and edges with the clock enable set and cleared;
- loads while the output is disabled;
- partly and fully undriven inputs.

Each sequence separates two behaviours. Level sensitivity is told apart from edge sensitivity. A held value is told apart from a freshly loaded one. A gated edge is told apart from an accepted one. A held bus bit is told apart from a driven one. Directed steps check the reset state and the value kept after a transparent phase. Another directed step clocks one direction while the other stays still, to show the two paths are isolated.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  typedef struct packed {
    logic le;
    logic ck;
    logic cken_n;
    logic oe_n;
  } bxc_ctl_t;
endpackage

// File: rtl/bxc_hold.sv
module bxc_hold #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] dvld,
  output logic [W-1:0] eff
);
  logic [W-1:0] held_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          held_q[i] <= 1'b0;
      else if (dvld[i]) held_q[i] <= din[i];
    end
    assign eff[i] = dvld[i] ? din[i] : held_q[i];
  end
endmodule

// File: rtl/bxc_store.sv
module bxc_store
  import bxc_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  bxc_ctl_t     ctl,
  input  logic [W-1:0] eff,
  output logic [W-1:0] path
);
  logic         ck_q;
  logic         rise;
  logic         load;
  logic [W-1:0] stor_q;

  always_ff @(posedge clk) ck_q <= ctl.ck;

  assign rise = ctl.ck & ~ck_q;
  assign load = ctl.le | (rise & ~ctl.cken_n);

  always_ff @(posedge clk) begin
    if (rst)       stor_q <= '0;
    else if (load) stor_q <= eff;
  end

  assign path = ctl.le ? eff : stor_q;
endmodule

// File: rtl/bxc_drive.sv
module bxc_drive #(
  parameter int W = 18
) (
  input  logic         oe_n,
  input  logic [W-1:0] path,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);
  assign doe  = {W{~oe_n}};
  assign dout = oe_n ? '0 : path;
endmodule

// File: rtl/bxc_xcvr.sv
module bxc_xcvr
  import bxc_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_vld,
  input  logic         oe_ab_n,
  input  logic         le_ab,
  input  logic         ck_ab,
  input  logic         cken_ab_n,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_vld,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         ck_ba,
  input  logic         cken_ba_n,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe
);
  logic [W-1:0] src  [NUM_DIR];
  logic [W-1:0] msk  [NUM_DIR];
  logic [W-1:0] dst  [NUM_DIR];
  logic [W-1:0] dsto [NUM_DIR];
  bxc_ctl_t     ctl  [NUM_DIR];

  assign src[DIR_AB] = a_in;
  assign msk[DIR_AB] = a_in_vld;
  assign ctl[DIR_AB] = '{le: le_ab, ck: ck_ab, cken_n: cken_ab_n, oe_n: oe_ab_n};
  assign src[DIR_BA] = b_in;
  assign msk[DIR_BA] = b_in_vld;
  assign ctl[DIR_BA] = '{le: le_ba, ck: ck_ba, cken_n: cken_ba_n, oe_n: oe_ba_n};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [W-1:0] eff;
    logic [W-1:0] path;

    bxc_hold #(.W(W)) u_hold (
      .clk (clk), .rst (rst), .din (src[d]), .dvld (msk[d]), .eff (eff)
    );
    bxc_store #(.W(W)) u_store (
      .clk (clk), .rst (rst), .ctl (ctl[d]), .eff (eff), .path (path)
    );
    bxc_drive #(.W(W)) u_drive (
      .oe_n (ctl[d].oe_n), .path (path), .dout (dst[d]), .doe (dsto[d])
    );
  end

  assign b_out = dst[DIR_AB];
  assign b_oe  = dsto[DIR_AB];
  assign a_out = dst[DIR_BA];
  assign a_oe  = dsto[DIR_BA];
endmodule

// File: rtl/bxc_xcvr_chk.sv
module bxc_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_in_vld,
  input logic         oe_ab_n,
  input logic         le_ab,
  input logic         ck_ab,
  input logic         cken_ab_n,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_in_vld,
  input logic         oe_ba_n,
  input logic         le_ba,
  input logic         ck_ba,
  input logic         cken_ba_n,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe
);
  // R2: transparent with fully driven input
  p_transp_ab_r2: assert property (@(posedge clk) disable iff (rst)
    (le_ab && !oe_ab_n && (&a_in_vld)) |-> (b_out == a_in));
  p_transp_ba_r2: assert property (@(posedge clk) disable iff (rst)
    (le_ba && !oe_ba_n && (&b_in_vld)) |-> (a_out == b_in));

  // R3: no edge and latch closed keeps the value
  p_hold_ab_r3: assert property (@(posedge clk) disable iff (rst)
    (!le_ab && !oe_ab_n && !$rose(ck_ab)) |=> (le_ab || oe_ab_n || $stable(b_out)));
  p_hold_ba_r3: assert property (@(posedge clk) disable iff (rst)
    (!le_ba && !oe_ba_n && !$rose(ck_ba)) |=> (le_ba || oe_ba_n || $stable(a_out)));

  // R4: enabled edge loads the driven input
  p_load_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (!le_ab && !cken_ab_n && $rose(ck_ab) && (&a_in_vld))
      |=> (le_ab || oe_ab_n || b_out == $past(a_in)));
  p_load_ba_r4: assert property (@(posedge clk) disable iff (rst)
    (!le_ba && !cken_ba_n && $rose(ck_ba) && (&b_in_vld))
      |=> (le_ba || oe_ba_n || a_out == $past(b_in)));

  // R5: gated edges are ignored
  p_gate_ab_r5: assert property (@(posedge clk) disable iff (rst)
    (!le_ab && cken_ab_n && !oe_ab_n) |=> (le_ab || oe_ab_n || $stable(b_out)));
  p_gate_ba_r5: assert property (@(posedge clk) disable iff (rst)
    (!le_ba && cken_ba_n && !oe_ba_n) |=> (le_ba || oe_ba_n || $stable(a_out)));

  // R7: disabled output is quiet
  p_hiz_ab_r7: assert property (@(posedge clk) disable iff (rst)
    oe_ab_n |-> (b_oe == '0 && b_out == '0));
  p_hiz_ba_r7: assert property (@(posedge clk) disable iff (rst)
    oe_ba_n |-> (a_oe == '0 && a_out == '0));
  p_drv_ab_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_ab_n |-> (&b_oe));
  p_drv_ba_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_ba_n |-> (&a_oe));
endmodule

bind bxc_xcvr bxc_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bxc_xcvr.sv
`timescale 1ns/1ps
module tb_bxc_xcvr;
  localparam int W = 18;
  localparam int NV = 16;
  localparam logic [W-1:0] ALL = '1;
  localparam logic [W-1:0] BA_X = 18'h2AAAA;

  // step vector: le, ck, cken_n, oe_n, vld[17:0], data[17:0]
  localparam logic [39:0] TBL [NV] = '{
    {4'b1000, ALL,      18'h12345},
    {4'b1000, ALL,      18'h3C3C3},
    {4'b0000, ALL,      18'h00FFF},
    {4'b0100, ALL,      18'h00FFF},
    {4'b0100, ALL,      18'h2AAAA},
    {4'b0000, ALL,      18'h15555},
    {4'b0110, ALL,      18'h15555},
    {4'b0010, ALL,      18'h15555},
    {4'b0100, ALL,      18'h15555},
    {4'b0001, ALL,      18'h0F0F0},
    {4'b0101, ALL,      18'h0F0F0},
    {4'b0100, ALL,      18'h33333},
    {4'b1000, 18'h000FF, 18'h3FF00},
    {4'b1000, 18'h00000, 18'h3FFFF},
    {4'b0000, ALL,      18'h00001},
    {4'b0100, ALL,      18'h00001}
  };

  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = '0, a_in_vld = '0, b_in = '0, b_in_vld = '0;
  logic oe_ab_n = 0, le_ab = 0, ck_ab = 0, cken_ab_n = 0;
  logic oe_ba_n = 0, le_ba = 0, ck_ba = 0, cken_ba_n = 0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0, errors = 0;
  logic [W-1:0] m_hold [2];
  logic [W-1:0] m_stor [2];
  logic [W-1:0] m_eff  [2];
  logic         m_ckq  [2];
  logic         m_lep  [2];

  always #5 clk = ~clk;

  bxc_xcvr #(.W(W)) dut (.*);

  function automatic string tag_of(input logic [39:0] v, input logic ckq, input logic lep);
    if (v[36]) return "R7";
    if (v[39] && v[35:18] != ALL) return "R8";
    if (v[39]) return "R2";
    if (lep) return "R6";
    if (v[38] && !ckq && !v[37]) return "R4";
    if (v[38] && !ckq && v[37]) return "R5";
    return "R3";
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input int d, input logic [39:0] v);
    logic [W-1:0] eff;
    eff = (v[W-1:0] & v[35:18]) | (m_hold[d] & ~v[35:18]);
    m_eff[d] = eff;
    if (v[39]) m_stor[d] = eff;
    else if (v[38] && !m_ckq[d] && !v[37]) m_stor[d] = eff;
    m_hold[d] = eff;
    m_ckq[d] = v[38];
  endtask

  task automatic step(input logic [39:0] va, input logic [39:0] vb, input string force_tag);
    string ta, tb;
    logic [W-1:0] ea, eb;
    @(negedge clk);
    {le_ab, ck_ab, cken_ab_n, oe_ab_n, a_in_vld, a_in} = va;
    {le_ba, ck_ba, cken_ba_n, oe_ba_n, b_in_vld, b_in} = vb;
    ta = (force_tag != "") ? force_tag : tag_of(va, m_ckq[0], m_lep[0] && !va[39]);
    tb = (force_tag != "") ? force_tag : tag_of(vb, m_ckq[1], m_lep[1] && !vb[39]);
    @(posedge clk);
    model_edge(0, va);
    model_edge(1, vb);
    m_lep[0] = va[39];
    m_lep[1] = vb[39];
    #2;
    ea = va[36] ? '0 : (va[39] ? m_eff[0] : m_stor[0]);
    eb = vb[36] ? '0 : (vb[39] ? m_eff[1] : m_stor[1]);
    check(ta, "b_out", b_out, ea);
    check(ta, "b_oe",  b_oe,  va[36] ? '0 : ALL);
    check(tb, "a_out", a_out, eb);
    check(tb, "a_oe",  a_oe,  vb[36] ? '0 : ALL);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_hold[d] = '0; m_stor[d] = '0; m_eff[d] = '0; m_ckq[d] = 0; m_lep[d] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state, latch closed, output on
    step({4'b0000, ALL, 18'h3FFFF}, {4'b0000, ALL, 18'h3FFFF}, "R1");

    // table walk, both directions
    for (int i = 0; i < NV; i++) begin
      logic [39:0] vb;
      vb = TBL[i];
      vb[W-1:0] = TBL[i][W-1:0] ^ BA_X;
      step(TBL[i], vb, "");
    end

    // R6: transparent value kept after latch enable falls
    step({4'b1000, ALL, 18'h2468A}, {4'b1000, ALL, 18'h13579}, "R6");
    step({4'b0000, ALL, 18'h00000}, {4'b0000, ALL, 18'h3FFFF}, "R6");

    // R9: clock A-to-B only; B-to-A keeps its value
    step({4'b0100, ALL, 18'h1ABCD}, {4'b0000, ALL, 18'h00007}, "R9");
    step({4'b0000, ALL, 18'h00000}, {4'b0100, ALL, 18'h05A5A}, "R9");
    step({4'b0110, ALL, 18'h3FFFF}, {4'b0000, ALL, 18'h11111}, "R9");

    // R8: undriven bits show the last driven value
    step({4'b1000, ALL, 18'h0000F}, {4'b1000, ALL, 18'h30000}, "R8");
    step({4'b1000, 18'h3FFF0, 18'h3FFF0}, {4'b1000, 18'h0FFFF, 18'h0000F}, "R8");
    step({4'b0000, 18'h00000, 18'h00000}, {4'b0000, 18'h00000, 18'h00000}, "R8");
    step({4'b0100, 18'h00000, 18'h12345}, {4'b0100, 18'h00000, 18'h12345}, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule